// File: doc/BRIEF.md
# Interrupt Source Sense and Configuration Slice

This block is the per-source front end of a multiprocessor interrupt controller. It holds the configuration of a single interrupt source in two word-wide registers. The first holds the vector and priority. The second holds the destination mask, with one bit per processor. The block samples the raw interrupt line through a synchronizer and decides, for each transition of that line, one of three outcomes. The transition can raise a new request. It can be ignored. For a level-sensitive source, it can withdraw a request that is still pending.

The slice keeps two masks with one bit per destination: the pending mask and the in-service mask. It presents both to the delivery logic. When a fresh request arises, it emits a single-cycle request pulse that carries the priority, the vector and the target mask. Routing and the acknowledge and end-of-service handshakes live in other blocks. Those blocks report back through two per-destination strobes. One strobe says a destination took the request. The other says a destination finished servicing it.

Top module: `isrc_slice`

## Requirements
- R1: After reset the configuration word reads 0x8000_0000 (masked, everything else zero), the target register reads 0, both masks are 0 and no request is raised.
- R2: The configuration word (`reg_sel`=0) holds the mask at bit 31, level-sensitive at bit 22, positive polarity at bit 23, priority at bits 19:16 and vector at bits 7:0. A written priority keeps only the low 4 bits of bits 23:16 of the written data (modulo 16). Bits 28:24, 21:20 and 15:8 read as 0.
- R3: On an external source (default), bit 29 (the multicast flag) always reads 0 after a write. A write to the target register (`reg_sel`=1) keeps only the low N_DEST bits.
- R4: Bit 30 of the configuration word reads 1 exactly when the pending mask or the in-service mask is non-zero.
- R5: While the mask bit is 1, transitions on the interrupt line raise no request and leave the pending mask unchanged.
- R6: For an edge-sensitive source, the active edge is rising when polarity=1 and falling when polarity=0. An active edge on a source with no pending and no in-service bits produces a one-cycle `req_valid` pulse carrying priority, vector and target mask, and sets the pending mask to the target mask. The opposite edge is ignored.
- R7: For a level-sensitive source, a transition to the active level acts as in R6. A transition to the inactive level clears the whole pending mask.
- R8: An active transition while any in-service bit is set copies the in-service mask into the pending mask and raises no request. An active transition while only pending bits are set changes nothing.
- R9: A `svc_take` bit sets that in-service bit. On an edge-sensitive source it also clears the pending mask, while on a level-sensitive source the pending mask is kept. A `svc_done` bit clears that in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 1 | Raw, asynchronous interrupt line |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = configuration word, 1 = target mask |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| svc_take | input | N_DEST | Per-destination strobe: request taken into service |
| svc_done | input | N_DEST | Per-destination strobe: service finished |
| pend_mask | output | N_DEST | Pending mask |
| insvc_mask | output | N_DEST | In-service mask |
| req_valid | output | 1 | One-cycle new-request pulse |
| req_prio | output | 4 | Priority carried with the request |
| req_vector | output | 8 | Vector carried with the request |
| req_dest | output | N_DEST | Target mask carried with the request |

## Verification
The embedded properties watch, on every cycle, several rules that must always hold. A masked source never yields a request. A request always leaves the pending mask equal to its target. A level drop to the inactive side empties the pending mask. The take and done strobes set and clear their in-service bits, and written mask and priority fields land in the register. The bench scenarios show the outcomes that depend on history: which edge counts for each polarity, that a second event is ignored while pending, that the in-service mask is copied into pending, that level sources keep pending across a take, the readback layout and truncation, and the active status bit through a full take/done sequence.

// File: rtl/isrc_pkg.sv
// Shared constants and types for the interrupt source slice.
// Assumes a 32-bit register word; field positions are fixed by software.
package isrc_pkg;

    localparam int WORD_W      = 32;
    localparam int PRIO_W      = 4;
    localparam int VEC_W       = 8;
    localparam int BIT_MASK    = 31;
    localparam int BIT_ACTIVE  = 30;
    localparam int BIT_MCAST   = 29;
    localparam int BIT_POL     = 23;
    localparam int BIT_LEVEL   = 22;
    localparam int PRIO_LSB    = 16;
    localparam int VEC_LSB     = 0;

    typedef struct packed {
        logic              mask;
        logic              mcast;
        logic              pol;
        logic              lvl;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } src_cfg_t;

    typedef enum logic [1:0] {
        EV_NONE     = 2'd0,
        EV_ACTIVE   = 2'd1,
        EV_INACTIVE = 2'd2
    } sense_ev_t;

endpackage

// File: rtl/isrc_sync.sv
// Synchronizes the raw interrupt line and reports its transitions.
// Assumes STAGES >= 2; an edge is the synchronized level differing from
// a copy registered one clock earlier.
module isrc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], raw};
    end

    // Keep the last synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[LAST];
    end

    assign rise = chain[LAST] & ~prev;
    assign fall = ~chain[LAST] & prev;

endmodule

// File: rtl/isrc_sense.sv
// Classifies a transition as active or inactive for the configured polarity.
// Assumes at most one of rise/fall is set in a cycle.
module isrc_sense
    import isrc_pkg::*;
(
    input  logic      rise,
    input  logic      fall,
    input  logic      pol,
    output sense_ev_t ev
);
    logic to_active;
    logic to_inactive;

    // Map raw edges onto active/inactive transitions.
    always_comb begin
        to_active   = pol ? rise : fall;
        to_inactive = pol ? fall : rise;
        if (to_active)        ev = EV_ACTIVE;
        else if (to_inactive) ev = EV_INACTIVE;
        else                  ev = EV_NONE;
    end

endmodule

// File: rtl/isrc_cfg_regs.sv
// Configuration word and target mask of one source, with read mux.
// Assumes a single-cycle write strobe; reads are combinational on sel.
module isrc_cfg_regs
    import isrc_pkg::*;
#(
    parameter int N_DEST   = 4,
    parameter bit EXTERNAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              active,
    output src_cfg_t          cfg,
    output logic [N_DEST-1:0] dest,
    output logic [WORD_W-1:0] rdata
);
    logic mcast_w;

    generate
        if (EXTERNAL) begin : g_ext
            assign mcast_w = 1'b0;
        end else begin : g_int
            assign mcast_w = wdata[BIT_MCAST];
        end
    endgenerate

    // Capture the configuration word; priority keeps its low bits only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg       <= '0;
            cfg.mask  <= 1'b1;
        end else if (wr && !sel) begin
            cfg.mask  <= wdata[BIT_MASK];
            cfg.mcast <= mcast_w;
            cfg.pol   <= wdata[BIT_POL];
            cfg.lvl   <= wdata[BIT_LEVEL];
            cfg.prio  <= wdata[PRIO_LSB +: PRIO_W];
            cfg.vec   <= wdata[VEC_LSB +: VEC_W];
        end
    end

    // Capture the target mask, truncated to implemented destinations.
    always_ff @(posedge clk) begin
        if (!rst_n)          dest <= '0;
        else if (wr && sel)  dest <= wdata[N_DEST-1:0];
    end

    // Assemble the selected register for reading.
    always_comb begin
        rdata = '0;
        if (!sel) begin
            rdata[BIT_MASK]             = cfg.mask;
            rdata[BIT_ACTIVE]           = active;
            rdata[BIT_MCAST]            = cfg.mcast;
            rdata[BIT_POL]              = cfg.pol;
            rdata[BIT_LEVEL]            = cfg.lvl;
            rdata[PRIO_LSB +: PRIO_W]   = cfg.prio;
            rdata[VEC_LSB +: VEC_W]     = cfg.vec;
        end else begin
            rdata[N_DEST-1:0]           = dest;
        end
    end

    p_wr_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sel) |=> (cfg.mask == $past(wdata[BIT_MASK])));

    p_wr_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sel) |=> (cfg.prio == $past(wdata[PRIO_LSB +: PRIO_W])));

endmodule

// File: rtl/isrc_track.sv
// Pending and in-service tracking plus the new-request decision.
// Assumes take/done strobes come from the delivery side; an input event in
// the same cycle as a take decides the pending mask.
module isrc_track
    import isrc_pkg::*;
#(
    parameter int N_DEST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sense_ev_t         ev,
    input  src_cfg_t          cfg,
    input  logic [N_DEST-1:0] dest,
    input  logic [N_DEST-1:0] take,
    input  logic [N_DEST-1:0] done,
    output logic [N_DEST-1:0] pend,
    output logic [N_DEST-1:0] insvc,
    output logic              req_valid,
    output logic [PRIO_W-1:0] req_prio,
    output logic [VEC_W-1:0]  req_vec,
    output logic [N_DEST-1:0] req_dest
);
    logic [N_DEST-1:0] pend_n;
    logic [N_DEST-1:0] insvc_n;
    logic [N_DEST-1:0] rdest_n;
    logic              req_n;

    // Decide the next masks and whether a fresh request is raised.
    always_comb begin
        pend_n  = pend;
        insvc_n = (insvc | take) & ~done;
        rdest_n = '0;
        req_n   = 1'b0;
        if ((|take) && !cfg.lvl)
            pend_n = cfg.mcast ? (pend & ~take) : '0;
        if (!cfg.mask) begin
            if (cfg.mcast) begin
                if (ev == EV_ACTIVE) begin
                    rdest_n = dest & ~pend;
                    pend_n  = pend | dest;
                    req_n   = |rdest_n;
                end
            end else if (ev == EV_INACTIVE) begin
                if (cfg.lvl) pend_n = '0;
            end else if (ev == EV_ACTIVE) begin
                if (|insvc) begin
                    pend_n = insvc;
                end else if (pend == '0) begin
                    req_n   = 1'b1;
                    rdest_n = dest;
                    pend_n  = dest;
                end
            end
        end
    end

    // Register the masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            insvc <= '0;
        end else begin
            pend  <= pend_n;
            insvc <= insvc_n;
        end
    end

    // Register the request pulse and its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_prio  <= '0;
            req_vec   <= '0;
            req_dest  <= '0;
        end else begin
            req_valid <= req_n;
            req_prio  <= cfg.prio;
            req_vec   <= cfg.vec;
            req_dest  <= rdest_n;
        end
    end

    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !$past(cfg.mask));

    p_req_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !$past(cfg.mcast)) |-> (pend == req_dest));

    p_withdraw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.mask && !cfg.mcast && cfg.lvl && ev == EV_INACTIVE) |=> (pend == '0));

    p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> ((insvc & $past(done)) == '0));

    p_take_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(take & ~done)) |=> ((insvc & $past(take & ~done)) == $past(take & ~done)));

endmodule

// File: rtl/isrc_slice.sv
// One interrupt source slice: synchronizer, sense classification,
// configuration registers and pending/in-service tracking.
// Assumes irq_in may be asynchronous; all other inputs are synchronous.
module isrc_slice #(
    parameter int N_DEST      = 4,
    parameter int SYNC_STAGES = 2,
    parameter bit EXTERNAL    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_in,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [N_DEST-1:0] svc_take,
    input  logic [N_DEST-1:0] svc_done,
    output logic [N_DEST-1:0] pend_mask,
    output logic [N_DEST-1:0] insvc_mask,
    output logic              req_valid,
    output logic [3:0]        req_prio,
    output logic [7:0]        req_vector,
    output logic [N_DEST-1:0] req_dest
);
    import isrc_pkg::*;

    logic              rise;
    logic              fall;
    sense_ev_t         ev;
    src_cfg_t          cfg;
    logic [N_DEST-1:0] dest;
    logic              active;

    assign active = (|pend_mask) | (|insvc_mask);

    isrc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (irq_in),
        .rise (rise),
        .fall (fall)
    );

    isrc_sense u_sense (
        .rise(rise),
        .fall(fall),
        .pol (cfg.pol),
        .ev  (ev)
    );

    isrc_cfg_regs #(.N_DEST(N_DEST), .EXTERNAL(EXTERNAL)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .active(active),
        .cfg   (cfg),
        .dest  (dest),
        .rdata (reg_rdata)
    );

    isrc_track #(.N_DEST(N_DEST)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .cfg      (cfg),
        .dest     (dest),
        .take     (svc_take),
        .done     (svc_done),
        .pend     (pend_mask),
        .insvc    (insvc_mask),
        .req_valid(req_valid),
        .req_prio (req_prio),
        .req_vec  (req_vector),
        .req_dest (req_dest)
    );

endmodule

// File: tb/tb_isrc_slice.sv
module tb_isrc_slice;
    localparam int ND = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_in = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [ND-1:0] svc_take = '0;
    logic [ND-1:0] svc_done = '0;
    logic [ND-1:0] pend_mask;
    logic [ND-1:0] insvc_mask;
    logic          req_valid;
    logic [3:0]    req_prio;
    logic [7:0]    req_vector;
    logic [ND-1:0] req_dest;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [31:0] exp_q[$];

    isrc_slice #(.N_DEST(ND)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .svc_take(svc_take), .svc_done(svc_done),
        .pend_mask(pend_mask), .insvc_mask(insvc_mask),
        .req_valid(req_valid), .req_prio(req_prio), .req_vector(req_vector), .req_dest(req_dest)
    );

    always #4 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(logic sel, logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic chk_rd(string tag, logic sel, logic [31:0] exp);
        reg_sel = sel;
        @(negedge clk);
        check(tag, reg_rdata, exp);
        tick(1);
    endtask

    task automatic set_irq(logic v);
        irq_in = v;
        tick(6);
    endtask

    task automatic strobe(logic [ND-1:0] tk, logic [ND-1:0] dn);
        svc_take = tk; svc_done = dn;
        tick(1);
        svc_take = '0; svc_done = '0;
        tick(2);
    endtask

    // Driver side of the scoreboard: queue an expected request.
    task automatic expect_req(logic [3:0] p, logic [7:0] v, logic [ND-1:0] d);
        exp_q.push_back({16'h0, p, v, {(4-ND){1'b0}}, d});
    endtask

    task automatic drained(string tag);
        check(tag, exp_q.size(), 0);
    endtask

    // Monitor: pop and compare every request pulse.
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            if (exp_q.size() == 0) begin
                check("R5/R6/R8 unexpected request", {16'h0, req_prio, req_vector, {(4-ND){1'b0}}, req_dest}, 32'hFFFF_FFFF);
            end else begin
                check("R6/R7 request payload", {16'h0, req_prio, req_vector, {(4-ND){1'b0}}, req_dest}, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk_rd("R1 cfg reset", 1'b0, 32'h8000_0000);
        chk_rd("R1 dest reset", 1'b1, 32'h0);
        check("R1 masks reset", {pend_mask, insvc_mask}, 0);
        // R5 masked source ignores input
        set_irq(1'b1);
        set_irq(1'b0);
        check("R5 masked pending", pend_mask, 0);
        // R2/R3 layout, priority modulo, multicast forced off, dest truncation
        wr_reg(1'b0, 32'h20DF_0042);
        chk_rd("R2 R3 cfg readback", 1'b0, 32'h00CF_0042);
        wr_reg(1'b1, 32'h0000_00FF);
        chk_rd("R3 dest truncation", 1'b1, 32'h0000_000F);
        // R6 positive edge source
        wr_reg(1'b1, 32'h5);
        wr_reg(1'b0, 32'h0085_0011);
        chk_rd("R2 edge cfg readback", 1'b0, 32'h0085_0011);
        expect_req(4'd5, 8'h11, 4'h5);
        set_irq(1'b1);
        drained("R6 rising edge request");
        check("R6 pending set", pend_mask, 4'h5);
        chk_rd("R4 active while pending", 1'b0, 32'h4085_0011);
        set_irq(1'b0);
        check("R6 falling edge ignored", pend_mask, 4'h5);
        set_irq(1'b1);
        check("R8 event while pending", pend_mask, 4'h5);
        set_irq(1'b0);
        // R9 take on edge source clears pending
        strobe(4'h1, 4'h0);
        check("R9 take edge pend", pend_mask, 4'h0);
        check("R9 take insvc", insvc_mask, 4'h1);
        chk_rd("R4 active while in service", 1'b0, 32'h4085_0011);
        // R8 event while in service copies in-service into pending
        set_irq(1'b1);
        check("R8 pend copies insvc", pend_mask, 4'h1);
        set_irq(1'b0);
        strobe(4'h0, 4'h1);
        check("R9 done clears insvc", insvc_mask, 4'h0);
        check("R9 pend kept after done", pend_mask, 4'h1);
        strobe(4'h1, 4'h0);
        strobe(4'h0, 4'h1);
        chk_rd("R4 inactive when clear", 1'b0, 32'h0085_0011);
        // R6 negative edge source
        wr_reg(1'b1, 32'h2);
        wr_reg(1'b0, 32'h0003_0022);
        set_irq(1'b1);
        check("R6 neg source ignores rise", pend_mask, 4'h0);
        expect_req(4'd3, 8'h22, 4'h2);
        set_irq(1'b0);
        drained("R6 falling edge request");
        strobe(4'h2, 4'h0);
        strobe(4'h0, 4'h2);
        check("R9 neg source cleared", {pend_mask, insvc_mask}, 0);
        // R7 level, active high
        wr_reg(1'b1, 32'h8);
        wr_reg(1'b0, 32'h00C7_0033);
        expect_req(4'd7, 8'h33, 4'h8);
        set_irq(1'b1);
        drained("R7 level high request");
        strobe(4'h8, 4'h0);
        check("R9 level keeps pending", pend_mask, 4'h8);
        set_irq(1'b0);
        check("R7 withdraw on drop", pend_mask, 4'h0);
        strobe(4'h0, 4'h8);
        check("R9 level insvc cleared", insvc_mask, 4'h0);
        // R7 level, active low
        wr_reg(1'b1, 32'h1);
        wr_reg(1'b0, 32'h0049_0044);
        set_irq(1'b1);
        check("R7 inactive edge no request", pend_mask, 4'h0);
        expect_req(4'd9, 8'h44, 4'h1);
        set_irq(1'b0);
        drained("R7 level low request");
        set_irq(1'b1);
        check("R7 active-low withdraw", pend_mask, 4'h0);
        // R5 mask set on a configured source
        wr_reg(1'b0, 32'h8085_0011);
        set_irq(1'b0);
        set_irq(1'b1);
        check("R5 masked edge ignored", pend_mask, 4'h0);
        drained("R5 no request queued");
        tick(4);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule